// File: doc/BRIEF.md
# Polarity-Configurable Serial Slave Port

This block is a 16-bit serial slave that runs from a serial clock and an active-low frame sync, both supplied by an external master. During each frame it shifts a word in from a data input and shifts a word out on a data output, most significant bit first. A polarity input selects which serial clock edge launches output bits and which edge samples input bits. The falling edge of the frame sync can also launch the first output bit. Whether it does depends on the level of the serial clock when the frame sync falls.

The serial pins are brought into the system clock domain through a synchronizer before any edge detection, so all state changes happen on system clock edges. On the host side there is a parallel load strobe for the word to transmit, and a one-cycle strobe that presents each received word.

Three externally clocked modes are supported:
- A three-wire mode, which is the default.
- A QSPI-style mode, which drives the output only inside a frame.
- A two-wire mode, in which the single data pin carries input and output in separate frames.

The two mode codes that would need an internally generated clock leave the port idle.

Top module: `pol_sport_slave`

## Requirements
- R1: Each frame carries exactly 16 bits, MSB first. After the 16th sampling edge, rx_data_o shows the received word and rx_valid_o is high for exactly one system clock.
- R2: With polarity_i = 0, sdo_o changes after a rising serial clock edge and sdi_i is sampled on the falling edge.
- R3: With polarity_i = 1, sdo_o changes after a falling serial clock edge and sdi_i is sampled on the rising edge.
- R4: If sclk_i is already at its launch level when fs_ni falls (high for polarity 0, low for polarity 1), the frame sync edge launches the MSB. Otherwise the MSB appears on the first launch edge.
- R5: While fs_ni is high, the bit counter and the shift register are held cleared. A partial word is discarded without a strobe, and the next falling edge of fs_ni starts a fresh 16-bit word.
- R6: With fs_ni held low, words follow back to back. After every 16th sampling edge the counter restarts and the transmit register reloads.
- R7: mode_i = 00 with two_wire_i = 0 selects three-wire mode, in which sdo_oe_o is constantly 1.
- R8: mode_i = 01 selects QSPI-style mode, in which sdo_oe_o is 1 only while the synchronized frame sync is low.
- R9: mode_i = 00 with two_wire_i = 1 selects two-wire mode. A frame that starts while a loaded word is pending is an output frame: sdo_oe_o is 1 and no receive strobe is given. Any other frame keeps sdo_oe_o at 0 and receives a word from sdi_i.
- R10: mode_i = 10 or 11 disables the port: sdo_oe_o is 0 and no receive strobe occurs.
- R11: After reset, rx_data_o, rx_valid_o and sdo_o are all 0.
- R12: tx_load_i captures tx_data_i. A frame transmits the word most recently loaded before it starts, and a load made during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | External serial clock |
| fs_ni | input | 1 | External frame sync, active low |
| sdi_i | input | 1 | Serial data in (the shared pin in two-wire mode) |
| polarity_i | input | 1 | Launch and sample edge select |
| mode_i | input | 2 | Interface mode code |
| two_wire_i | input | 1 | Control bit that enables two-wire mode when mode_i is 00 |
| tx_data_i | input | 16 | Word to transmit |
| tx_load_i | input | 1 | Load strobe for tx_data_i |
| rx_data_o | output | 16 | Last received word |
| rx_valid_o | output | 1 | One-cycle strobe for a received word |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o |

## Verification
If the bit counter or a shift register holds a wrong value, the fault shows at the ports within a single frame:
- An off-by-one count moves or removes the receive strobe, and the received word comes out rotated.
- A wrong launch decision at the frame sync edge shifts every transmitted bit by one position. The first mismatch is seen on sdo_o one half serial clock after the frame starts.
- A wrong frame type in two-wire mode inverts sdo_oe_o while the frame is still in progress, and the receive strobe is lost.

// File: rtl/pol_sport_pkg.sv
package pol_sport_pkg;
  typedef enum logic [1:0] {
    MODE_3W   = 2'd0,
    MODE_QSPI = 2'd1,
    MODE_2W   = 2'd2,
    MODE_OFF  = 2'd3
  } port_mode_e;
endpackage

// File: rtl/pol_sport_sync.sv
module pol_sport_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST_VAL;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pol_sport_edge.sv
module pol_sport_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/pol_sport_core.sv
module pol_sport_core #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              launch_i,
  input  logic              capture_i,
  input  logic              at_launch_lvl_i,
  input  logic              two_wire_i,
  input  logic              sdi_i,
  input  logic              tx_load_i,
  input  logic [WORD_W-1:0] tx_data_i,
  output logic              sdo_o,
  output logic              out_frame_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  localparam int unsigned CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [CW-1:0]     cnt_q;
  logic [WORD_W-1:0] rx_sh_q, tx_sh_q, tx_hold_q;
  logic              frame_q, tx_pend_q;
  logic              start, launch_any;

  assign start      = frame_i & ~frame_q;
  assign launch_any = launch_i | (start & at_launch_lvl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      rx_sh_q     <= '0;
      tx_sh_q     <= '0;
      tx_hold_q   <= '0;
      tx_pend_q   <= 1'b0;
      frame_q     <= 1'b0;
      out_frame_o <= 1'b0;
      sdo_o       <= 1'b0;
      rx_data_o   <= '0;
      rx_valid_o  <= 1'b0;
    end else begin
      frame_q    <= frame_i;
      rx_valid_o <= 1'b0;
      if (!frame_i) begin
        cnt_q       <= '0;
        rx_sh_q     <= '0;
        tx_sh_q     <= tx_hold_q;
        out_frame_o <= 1'b0;
      end else begin
        if (start) begin
          out_frame_o <= two_wire_i & tx_pend_q;
          if (two_wire_i) tx_pend_q <= 1'b0;
        end
        if (launch_any) begin
          sdo_o   <= tx_sh_q[WORD_W-1];
          tx_sh_q <= tx_sh_q << 1;
        end
        if (capture_i) begin
          if (cnt_q == LAST) begin
            // word complete: restart for a back-to-back word
            cnt_q       <= '0;
            rx_sh_q     <= '0;
            tx_sh_q     <= tx_hold_q;
            out_frame_o <= two_wire_i & tx_pend_q;
            if (two_wire_i) tx_pend_q <= 1'b0;
            if (!out_frame_o) begin
              rx_data_o  <= {rx_sh_q[WORD_W-2:0], sdi_i};
              rx_valid_o <= 1'b1;
            end
          end else begin
            cnt_q   <= cnt_q + 1'b1;
            rx_sh_q <= {rx_sh_q[WORD_W-2:0], sdi_i};
          end
        end
      end
      if (tx_load_i) begin
        tx_hold_q <= tx_data_i;
        tx_pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pol_sport_slave.sv
module pol_sport_slave
  import pol_sport_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              fs_ni,
  input  logic              sdi_i,
  input  logic              polarity_i,
  input  logic [1:0]        mode_i,
  input  logic              two_wire_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_load_i,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  port_mode_e mode;
  logic [2:0] pins_s;
  logic       sclk_s, fs_s, sdi_s;
  logic       sclk_rise, sclk_fall;
  logic       port_en, frame_act, launch, capture, out_frame;

  always_comb begin
    unique case (mode_i)
      2'b00:   mode = two_wire_i ? MODE_2W : MODE_3W;
      2'b01:   mode = MODE_QSPI;
      default: mode = MODE_OFF;
    endcase
  end

  pol_sport_sync #(
    .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, fs_ni, sdi_i}),
    .q_o   (pins_s)
  );
  assign {sclk_s, fs_s, sdi_s} = pins_s;

  pol_sport_edge u_sclk_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (sclk_s),
    .rise_o(sclk_rise),
    .fall_o(sclk_fall)
  );

  assign port_en   = (mode != MODE_OFF);
  assign frame_act = port_en & ~fs_s;
  assign launch    = frame_act & (polarity_i ? sclk_fall : sclk_rise);
  assign capture   = frame_act & (polarity_i ? sclk_rise : sclk_fall);

  pol_sport_core #(.WORD_W(WORD_W)) u_core (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .frame_i        (frame_act),
    .launch_i       (launch),
    .capture_i      (capture),
    .at_launch_lvl_i(sclk_s != polarity_i),
    .two_wire_i     (mode == MODE_2W),
    .sdi_i          (sdi_s),
    .tx_load_i      (tx_load_i),
    .tx_data_i      (tx_data_i),
    .sdo_o          (sdo_o),
    .out_frame_o    (out_frame),
    .rx_data_o      (rx_data_o),
    .rx_valid_o     (rx_valid_o)
  );

  always_comb begin
    unique case (mode)
      MODE_3W:   sdo_oe_o = 1'b1;
      MODE_QSPI: sdo_oe_o = frame_act;
      MODE_2W:   sdo_oe_o = frame_act & out_frame;
      default:   sdo_oe_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pol_sport_chk.sv
module pol_sport_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic              two_wire_i,
  input logic [WORD_W-1:0] rx_data_o,
  input logic              rx_valid_o,
  input logic              sdo_oe_o
);
  p_valid_one_cycle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  p_rx_change_on_strobe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_data_o) |-> rx_valid_o);

  p_three_wire_oe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 && !two_wire_i) |-> sdo_oe_o);

  p_two_wire_out_no_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && mode_i == 2'b00 && two_wire_i && $past(mode_i) == 2'b00 && $past(two_wire_i))
      |-> !$past(sdo_oe_o));

  p_off_no_oe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[1] |-> !sdo_oe_o);

  p_off_no_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && $past(mode_i[1])) |-> !rx_valid_o);
endmodule

bind pol_sport_slave pol_sport_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .two_wire_i(two_wire_i),
  .rx_data_o (rx_data_o),
  .rx_valid_o(rx_valid_o),
  .sdo_oe_o  (sdo_oe_o)
);

// File: tb/pol_sport_slave_tb_top.sv
module pol_sport_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, fs_n = 1'b1, sdi = 1'b0, pol = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        two_wire = 1'b0;
  logic [15:0] tx_data = '0;
  logic        tx_load = 1'b0;
  logic [15:0] rx_data;
  logic        rx_valid, sdo, sdo_oe;

  int checks = 0, failures = 0, pulses = 0;
  logic [15:0] last_rx = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pol_sport_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .fs_ni(fs_n), .sdi_i(sdi),
    .polarity_i(pol), .mode_i(mode), .two_wire_i(two_wire),
    .tx_data_i(tx_data), .tx_load_i(tx_load),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  always @(negedge clk) if (rx_valid) begin
    pulses  = pulses + 1;
    last_rx = rx_data;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic load_word(input logic [15:0] w);
    tx_data = w;
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  task automatic run_frame(input logic p, input logic st, input logic [15:0] txw, input logic [15:0] rxw,
                           input bit chk_tx, input int exp_pulses, input int exp_oe, input bit keep_low,
                           input bit load_mid, input logic [15:0] mid_word, input string tag);
    int base;
    bit fsl;
    base = pulses;
    fsl = 0;
    pol = p;
    if (fs_n) begin
      sclk = st;
      sdi = rxw[15];
      wait_hp();
      fs_n = 1'b0;
      fsl = (st != p);
      wait_hp();
    end
    for (int i = 0; i < 16; i++) begin
      if (!(i == 0 && fsl)) begin
        sclk = ~p;
        sdi = rxw[15-i];
        wait_hp();
      end
      if (chk_tx) check(sdo == txw[15-i], {tag, " tx bit"}, 32'(sdo), 32'(txw[15-i]));
      if (i == 8 && exp_oe >= 0) check(sdo_oe == exp_oe[0], {tag, " oe in frame"}, 32'(sdo_oe), 32'(exp_oe));
      if (i == 8 && load_mid) load_word(mid_word);
      sclk = p;
      wait_hp();
    end
    wait_hp();
    check(pulses == base + exp_pulses, {tag, " strobe count"}, 32'(pulses - base), 32'(exp_pulses));
    if (exp_pulses > 0) check(last_rx == rxw, {"R1 ", tag, " rx word"}, 32'(last_rx), 32'(rxw));
    if (!keep_low) begin
      fs_n = 1'b1;
      wait_hp();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] words [3];
    string tag;
    words[0] = 16'hA5C3;
    words[1] = 16'h0001;
    words[2] = 16'hFFFE;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rx_data == 16'h0, "R11 rx_data after reset", 32'(rx_data), 0);
    check(rx_valid == 1'b0, "R11 rx_valid after reset", 32'(rx_valid), 0);
    check(sdo == 1'b0, "R11 sdo after reset", 32'(sdo), 0);
    check(sdo_oe == 1'b1, "R7 oe in three-wire mode", 32'(sdo_oe), 1);

    // polarity x clock-level-at-frame-start x data sweep
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 2; s++)
        for (int w = 0; w < 3; w++) begin
          logic [15:0] rxw;
          rxw = {words[w][7:0], words[w][15:8]} ^ 16'h3C5A;
          tag = {(p != 0) ? "R3" : "R2", (s != p) ? " R4 fs-launch" : " R4 edge-launch", " R12"};
          load_word(words[w]);
          run_frame(p[0], s[0], words[w], rxw, 1, 1, 1, 0, 0, 16'h0, tag);
        end

    // R5: partial word aborted by frame sync
    begin
      int base;
      base = pulses;
      pol = 1'b0;
      sclk = 1'b0;
      wait_hp();
      fs_n = 1'b0;
      wait_hp();
      for (int i = 0; i < 5; i++) begin
        sclk = 1'b1; sdi = 1'b1; wait_hp();
        sclk = 1'b0; wait_hp();
      end
      fs_n = 1'b1;
      wait_hp();
      check(pulses == base, "R5 no strobe for partial word", 32'(pulses - base), 0);
      load_word(16'h5A5A);
      run_frame(1'b0, 1'b0, 16'h5A5A, 16'h8421, 1, 1, -1, 0, 0, 16'h0, "R5 fresh word after abort");
    end

    // R6/R12: frame sync held low, new word loaded mid-frame
    load_word(16'hC0DE);
    run_frame(1'b1, 1'b1, 16'hC0DE, 16'h1357, 1, 1, -1, 1, 1, 16'h7E81, "R6 R12 first of two");
    run_frame(1'b1, 1'b1, 16'h7E81, 16'hFACE, 1, 1, -1, 0, 0, 16'h0, "R6 R12 back-to-back");

    // R8: QSPI-style mode
    mode = 2'b01;
    wait_hp();
    check(sdo_oe == 1'b0, "R8 oe idle with frame sync high", 32'(sdo_oe), 0);
    load_word(16'h0F0F);
    run_frame(1'b0, 1'b1, 16'h0F0F, 16'hBEEF, 1, 1, 1, 0, 0, 16'h0, "R8 QSPI frame");
    check(sdo_oe == 1'b0, "R8 oe after frame", 32'(sdo_oe), 0);

    // R9: two-wire mode
    mode = 2'b00;
    two_wire = 1'b1;
    wait_hp();
    check(sdo_oe == 1'b0, "R9 oe idle in two-wire", 32'(sdo_oe), 0);
    load_word(16'h9C31);
    run_frame(1'b0, 1'b0, 16'h9C31, 16'h0000, 1, 0, 1, 0, 0, 16'h0, "R9 output frame");
    check(sdo_oe == 1'b0, "R9 oe after output frame", 32'(sdo_oe), 0);
    run_frame(1'b1, 1'b0, 16'h0000, 16'h6D2B, 0, 1, 0, 0, 0, 16'h0, "R9 receive frame");

    // R10: disabled modes
    two_wire = 1'b0;
    mode = 2'b10;
    wait_hp();
    check(sdo_oe == 1'b0, "R10 oe off for code 10", 32'(sdo_oe), 0);
    run_frame(1'b0, 1'b0, 16'h0, 16'h4444, 0, 0, 0, 0, 0, 16'h0, "R10 code 10 ignored");
    mode = 2'b11;
    wait_hp();
    check(sdo_oe == 1'b0, "R10 oe off for code 11", 32'(sdo_oe), 0);
    run_frame(1'b1, 1'b1, 16'h0, 16'h2222, 0, 0, 0, 0, 0, 16'h0, "R10 code 11 ignored");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule